// File: doc/BRIEF.md
# I/O Port Bitmap Exit Checker

This block decides whether a guest access to an I/O port must leave the guest, and it builds the word that describes the trapped access. An access is one to four bytes wide. When a start pulse arrives, the block captures the port, the length, the instruction class and two control bits. The instruction class covers direction, string form, repeat prefix and immediate-port form. Depending on the controls, the block then either decides at once or fetches two bytes of a port bitmap. It fetches them one at a time through a byte-read request/response port, tests the bits that the access covers, and reports the result with a one-cycle done strobe.

The port space is split between two bitmaps of 4 KiB each. Their base addresses are inputs. The low bitmap covers ports 0x0000-0x7FFF and the high bitmap covers ports 0x8000-0xFFFF. An access that runs past the end of the low bitmap takes its first byte from the last byte of the low bitmap and its second byte from the first byte of the high bitmap. An access that runs past port 0xFFFF exits without reading either bitmap.

Top module: `iobm_exit_checker`

## Requirements
- R1: After reset, `done_o`, `exit_o` and `rd_req_o` are low and `qual_o` is zero.
- R2: With `use_bitmap_i` low, the result is `exit_o` = `uncond_exit_i` and no bitmap byte is read.
- R3: With bitmaps in use, an access where port + length > 0x10000 exits and no bitmap byte is read.
- R4: With bitmaps in use and no straddle, the first read is at B + (port[14:0] >> 3) and the second read is at that address + 1. B is `bm1_base_i` when port[15] is 1 and `bm0_base_i` otherwise.
- R5: When (port & 0x7FFF) + length > 0x8000 and there is no wrap, the first read is at `bm0_base_i` + 0xFFF and the second read is at `bm1_base_i`.
- R6: The first byte read forms bits [7:0] and the second byte forms bits [15:8] of a 16-bit value. The access exits when that value AND (((1 << len) - 1) << port[2:0]) is nonzero.
- R7: `qual_o` packs [2:0] = length - 1, [3] = input direction, [4] = string form, [15:7] = 0 and [31:16] = port.
- R8: `qual_o[5]` (repeat) is set only when both `rep_i` and `string_i` are set. `qual_o[6]` (immediate port) is set only when `imm_port_i` is set and `string_i` is clear.
- R9: A length other than 1, 2 or 4 exits whatever the controls are, and no bitmap byte is read.
- R10: At most one read is outstanding, and `rd_addr_o` holds until `rd_valid_i` arrives. `done_o` is a single-cycle pulse, with `exit_o` and `qual_o` valid while it is high and held until the next result. A start pulse while a check is in progress is ignored.
- R11: A result that needs no read shows `done_o` in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a check; accepted only when idle |
| port_i | input | 16 | Port number of the access |
| len_i | input | 3 | Access length in bytes (1, 2 or 4) |
| dir_in_i | input | 1 | 1 for input (port to register) |
| string_i | input | 1 | String instruction form |
| rep_i | input | 1 | Repeat prefix present |
| imm_port_i | input | 1 | Port given as an immediate operand |
| use_bitmap_i | input | 1 | Consult the port bitmaps |
| uncond_exit_i | input | 1 | Exit on every access when bitmaps are not used |
| bm0_base_i | input | ADDR_W | Base address of the low-port bitmap |
| bm1_base_i | input | ADDR_W | Base address of the high-port bitmap |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| done_o | output | 1 | One-cycle completion strobe |
| exit_o | output | 1 | The access must exit |
| qual_o | output | 32 | Qualification word describing the access |

## Verification
If the captured request or the first fetched byte is corrupted, the fault shows at the next done strobe. It appears as a wrong exit flag or a wrong qualification word, or as read addresses that differ from the selected base plus offset. A broken sequencer shows within a transaction in other ways: a missing or extra read, an address that moves while a read is pending, or a done strobe that lasts more than one cycle or never comes. The bench sees this at the handshake port in the cycle it happens. Wrap and straddle faults show only for ports near 0x7FFF and 0xFFFF, so those ports are aimed at directly.

// File: rtl/iobm_pkg.sv
package iobm_pkg;

    localparam int PORT_W = 16;
    localparam int LEN_W  = 3;
    localparam int QUAL_W = 32;
    localparam int OFS_W  = 12;
    localparam int PAIR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_DONE
    } iobm_state_t;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [LEN_W-1:0]  len;
        logic              dir_in;
        logic              str;
        logic              rep;
        logic              imm;
        logic              use_bm;
        logic              uncond;
    } iobm_req_t;

    function automatic logic len_legal(input logic [LEN_W-1:0] l);
        return (l == 3'd1) || (l == 3'd2) || (l == 3'd4);
    endfunction

    function automatic logic [PAIR_W-1:0] span_mask(input logic [PORT_W-1:0] p,
                                                    input logic [LEN_W-1:0]  l);
        logic [PAIR_W-1:0] m;
        m = (PAIR_W'(1) << l) - PAIR_W'(1);
        return m << p[2:0];
    endfunction

endpackage

// File: rtl/iobm_plan.sv
module iobm_plan
    import iobm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [PORT_W-1:0] port,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              wrap,
    output logic [PAIR_W-1:0] mask
);
    localparam logic [PORT_W:0]   WRAP_LIMIT = 17'h1_0000;
    localparam logic [PORT_W-1:0] HALF_LIMIT = 16'h8000;
    localparam logic [ADDR_W-1:0] LAST_OFS   = ADDR_W'(12'hFFF);

    logic [PORT_W:0]   full_end;
    logic [PORT_W-1:0] half_end;
    logic              straddle;
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] byte_ofs;

    always_comb begin
        full_end = {1'b0, port} + (PORT_W+1)'(len);
        half_end = {1'b0, port[PORT_W-2:0]} + PORT_W'(len);
        wrap     = full_end > WRAP_LIMIT;
        straddle = half_end > HALF_LIMIT;
        sel_base = port[PORT_W-1] ? base1 : base0;
        byte_ofs = ADDR_W'(port[PORT_W-2:3]);
        if (straddle) begin
            addr_lo = base0 + LAST_OFS;
            addr_hi = base1;
        end else begin
            addr_lo = sel_base + byte_ofs;
            addr_hi = sel_base + byte_ofs + ADDR_W'(1);
        end
        mask = span_mask(port, len);
    end
endmodule

// File: rtl/iobm_qual.sv
module iobm_qual
    import iobm_pkg::*;
(
    input  logic [PORT_W-1:0] port,
    input  logic [LEN_W-1:0]  len,
    input  logic              dir_in,
    input  logic              str,
    input  logic              rep,
    input  logic              imm,
    output logic [QUAL_W-1:0] qual
);
    always_comb begin
        qual        = '0;
        qual[2:0]   = len - LEN_W'(1);
        qual[3]     = dir_in;
        qual[4]     = str;
        qual[5]     = rep & str;
        qual[6]     = imm & ~str;
        qual[31:16] = port;
    end
endmodule

// File: rtl/iobm_exit_checker.sv
module iobm_exit_checker
    import iobm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [15:0]       port_i,
    input  logic [2:0]        len_i,
    input  logic              dir_in_i,
    input  logic              string_i,
    input  logic              rep_i,
    input  logic              imm_port_i,
    input  logic              use_bitmap_i,
    input  logic              uncond_exit_i,
    input  logic [ADDR_W-1:0] bm0_base_i,
    input  logic [ADDR_W-1:0] bm1_base_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [7:0]        rd_data_i,
    output logic              done_o,
    output logic              exit_o,
    output logic [31:0]       qual_o
);
    iobm_state_t       state_q;
    iobm_req_t         req_in, req_q, req_cur;
    logic [7:0]        byte_lo_q;
    logic              exit_q;
    logic [QUAL_W-1:0] qual_q, qual_c;
    logic [ADDR_W-1:0] addr_lo, addr_hi;
    logic              wrap;
    logic [PAIR_W-1:0] mask;
    logic              idle;

    assign idle   = (state_q == ST_IDLE);
    assign req_in = '{port: port_i, len: len_i, dir_in: dir_in_i, str: string_i,
                      rep: rep_i, imm: imm_port_i, use_bm: use_bitmap_i,
                      uncond: uncond_exit_i};
    assign req_cur = idle ? req_in : req_q;

    iobm_plan #(.ADDR_W(ADDR_W)) u_plan (
        .port    (req_cur.port),
        .len     (req_cur.len),
        .base0   (bm0_base_i),
        .base1   (bm1_base_i),
        .addr_lo (addr_lo),
        .addr_hi (addr_hi),
        .wrap    (wrap),
        .mask    (mask)
    );

    iobm_qual u_qual (
        .port   (req_cur.port),
        .len    (req_cur.len),
        .dir_in (req_cur.dir_in),
        .str    (req_cur.str),
        .rep    (req_cur.rep),
        .imm    (req_cur.imm),
        .qual   (qual_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            byte_lo_q <= '0;
            exit_q    <= 1'b0;
            qual_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q  <= req_in;
                        qual_q <= qual_c;
                        if (!len_legal(len_i)) begin
                            exit_q  <= 1'b1;
                            state_q <= ST_DONE;
                        end else if (!use_bitmap_i) begin
                            exit_q  <= uncond_exit_i;
                            state_q <= ST_DONE;
                        end else if (wrap) begin
                            exit_q  <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_RD_LO;
                        end
                    end
                end
                ST_RD_LO: begin
                    if (rd_valid_i) begin
                        byte_lo_q <= rd_data_i;
                        state_q   <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (rd_valid_i) begin
                        exit_q  <= |({rd_data_i, byte_lo_q} & mask);
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_o  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
    assign rd_addr_o = (state_q == ST_RD_HI) ? addr_hi : addr_lo;
    assign done_o    = (state_q == ST_DONE);
    assign exit_o    = exit_q;
    assign qual_o    = qual_q;

    a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_no_read_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_req_o);

    a_r8_rep_needs_string: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(qual_o[5] && !qual_o[4]));

    a_r8_imm_not_string: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(qual_o[6] && qual_o[4]));

    a_r9_illegal_exits: assert property (@(posedge clk) disable iff (rst)
        (done_o && !len_legal(req_q.len)) |-> exit_o);

    a_r2_no_bitmap: assert property (@(posedge clk) disable iff (rst)
        (done_o && len_legal(req_q.len) && !req_q.use_bm) |-> (exit_o == req_q.uncond));

    a_r7_port_field: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (qual_o[31:16] == req_q.port));

endmodule

// File: tb/test_iobm_exit_checker.sv
`timescale 1ns/1ps
module test_iobm_exit_checker;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [15:0]   port_i = '0;
    logic [2:0]    len_i = 3'd1;
    logic          dir_in_i = 1'b0, string_i = 1'b0, rep_i = 1'b0, imm_port_i = 1'b0;
    logic          use_bitmap_i = 1'b0, uncond_exit_i = 1'b0;
    logic [AW-1:0] bm0_base_i = 32'h0001_0000;
    logic [AW-1:0] bm1_base_i = 32'h0002_3000;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          done_o, exit_o;
    logic [31:0]   qual_o;

    always #2.5 clk = ~clk;

    iobm_exit_checker #(.ADDR_W(AW)) i_iobm_exit_checker (
        .clk(clk), .rst(rst), .start_i(start_i), .port_i(port_i), .len_i(len_i),
        .dir_in_i(dir_in_i), .string_i(string_i), .rep_i(rep_i), .imm_port_i(imm_port_i),
        .use_bitmap_i(use_bitmap_i), .uncond_exit_i(uncond_exit_i),
        .bm0_base_i(bm0_base_i), .bm1_base_i(bm1_base_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .done_o(done_o), .exit_o(exit_o), .qual_o(qual_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int mem_mode = 0;
    logic [AW-1:0] hot_addr = '1;
    logic [7:0]    hot_val = '0;
    int        rd_cnt;
    logic [AW-1:0] rd_log [2];

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [7:0] h;
        h = a[7:0] ^ {a[10:8], a[15:11]} ^ (a[23:16] * 8'd37) ^ 8'h5A;
        if (a == hot_addr) return hot_val;
        case (mem_mode)
            0: return 8'h00;
            1: return 8'hFF;
            2: return h;
            default: return (h[7:5] == 3'd0) ? (8'h01 << h[2:0]) : 8'h00;
        endcase
    endfunction

    // Memory responder: random latency, one byte per request.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_o && !rst) begin
                repeat ($urandom % 3) @(negedge clk);
                rd_data_i  = mem_byte(rd_addr_o);
                if (rd_cnt < 2) rd_log[rd_cnt] = rd_addr_o;
                rd_cnt     = rd_cnt + 1;
                rd_valid_i = 1'b1;
                @(negedge clk);
                rd_valid_i = 1'b0;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    logic          e_exit;
    int            e_nrd;
    logic [AW-1:0] e_a0, e_a1;
    logic [31:0]   e_qual;

    task automatic model(input logic [15:0] p, input logic [2:0] l, input logic d,
                         input logic s, input logic r, input logic im,
                         input logic ub, input logic uc);
        logic [15:0] pair, m;
        e_qual = {p, 9'd0, im & ~s, r & s, s, d, 3'(l - 3'd1)};
        e_nrd = 0;
        e_a0 = '0;
        e_a1 = '0;
        if (!(l == 1 || l == 2 || l == 4)) e_exit = 1'b1;              // R9
        else if (!ub) e_exit = uc;                                      // R2
        else if (32'(p) + 32'(l) > 32'h10000) e_exit = 1'b1;            // R3
        else begin
            e_nrd = 2;
            if (32'(p[14:0]) + 32'(l) > 32'h8000) begin                // R5
                e_a0 = bm0_base_i + 32'hFFF;
                e_a1 = bm1_base_i;
            end else begin                                              // R4
                e_a0 = (p[15] ? bm1_base_i : bm0_base_i) + 32'(p[14:3]);
                e_a1 = e_a0 + 1;
            end
            pair = {mem_byte(e_a1), mem_byte(e_a0)};                    // R6
            m = ((16'd1 << l) - 16'd1) << p[2:0];
            e_exit = |(pair & m);
        end
    endtask

    bit timed_out = 0;

    task automatic run(input logic [15:0] p, input logic [2:0] l, input logic d,
                       input logic s, input logic r, input logic im,
                       input logic ub, input logic uc, input bit poke, input string tag);
        int waitc;
        int lat;
        model(p, l, d, s, r, im, ub, uc);
        @(negedge clk);
        rd_cnt = 0;
        port_i = p; len_i = l; dir_in_i = d; string_i = s; rep_i = r; imm_port_i = im;
        use_bitmap_i = ub; uncond_exit_i = uc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waitc = 0;
        lat = 1;
        while (!done_o && waitc < 100) begin
            if (poke && waitc == 0) begin
                // R10: a start while busy must be ignored
                port_i = ~p; len_i = 3'd3; use_bitmap_i = 1'b0; uncond_exit_i = 1'b0;
                start_i = 1'b1;
            end else start_i = 1'b0;
            @(negedge clk);
            waitc++;
            lat++;
        end
        start_i = 1'b0;
        if (!done_o) begin
            n_cmp++; n_bad++; timed_out = 1;
            $display("FAIL R10 watchdog: actual no done expected done (%s)", tag);
            return;
        end
        chk({tag, " R6 exit"}, 32'(exit_o), 32'(e_exit));
        chk({tag, " R7 qual"}, qual_o, e_qual);
        chk({tag, " R10 read count"}, 32'(rd_cnt), 32'(e_nrd));
        if (e_nrd == 2 && rd_cnt == 2) begin
            chk({tag, " R4 first addr"}, rd_log[0], e_a0);
            chk({tag, " R4 second addr"}, rd_log[1], e_a1);
        end
        if (e_nrd == 0) chk({tag, " R11 latency"}, 32'(lat), 32'd1);
        @(negedge clk);
        chk({tag, " R10 done pulse"}, 32'(done_o), 32'd0);
        chk({tag, " R10 held exit"}, 32'(exit_o), 32'(e_exit));
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL R10 global watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rd_cnt = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 done", 32'(done_o), 0);
        chk("R1 exit", 32'(exit_o), 0);
        chk("R1 rd_req", 32'(rd_req_o), 0);
        chk("R1 qual", qual_o, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 controls
        mem_mode = 1;
        run(16'h0060, 3'd1, 1, 0, 0, 1, 0, 1, 0, "R2 uncond");
        run(16'h0060, 3'd1, 1, 0, 0, 1, 0, 0, 0, "R2 off");
        // R3 wrap
        run(16'hFFFF, 3'd2, 0, 0, 0, 0, 1, 0, 0, "R3 wrap2");
        run(16'hFFFD, 3'd4, 0, 0, 0, 0, 1, 0, 0, "R3 wrap4");
        mem_mode = 0;
        run(16'hFFFC, 3'd4, 0, 0, 0, 0, 1, 0, 0, "R3 top fits");
        // R9 illegal lengths
        run(16'h0100, 3'd3, 0, 0, 0, 0, 0, 0, 0, "R9 len3");
        run(16'h0100, 3'd0, 0, 0, 0, 0, 1, 0, 0, "R9 len0");
        // R5 straddle: only the high bitmap byte bit 0 set
        hot_addr = bm1_base_i; hot_val = 8'h01;
        run(16'h7FFF, 3'd2, 1, 0, 0, 1, 1, 0, 0, "R5 straddle hit");
        hot_val = 8'h02;
        run(16'h7FFF, 3'd2, 1, 0, 0, 1, 1, 0, 0, "R5 straddle miss");
        // R4 high bitmap selection and R6 second-byte bits
        hot_addr = bm1_base_i + 32'h025; hot_val = 8'h01;
        run(16'h8123, 3'd4, 0, 0, 0, 0, 1, 0, 0, "R4 high map");
        run(16'h8127, 3'd2, 0, 0, 0, 0, 1, 0, 0, "R6 spill hit");
        run(16'h8126, 3'd1, 0, 0, 0, 0, 1, 0, 0, "R6 spill miss");
        hot_addr = '1;
        // R8 qualification forms
        mem_mode = 1;
        run(16'h1234, 3'd2, 1, 0, 1, 1, 0, 1, 0, "R8 rep no string");
        run(16'h4321, 3'd4, 0, 1, 1, 1, 0, 1, 0, "R8 imm with string");
        // R10 start while busy
        mem_mode = 2;
        run(16'h0345, 3'd2, 1, 1, 1, 0, 1, 0, 1, "R10 busy start");

        // Random mix
        for (int k = 0; k < 400 && !timed_out; k++) begin
            logic [15:0] p;
            logic [2:0]  l;
            int sel;
            sel = $urandom % 10;
            case (sel)
                0: p = 16'h7FF8 + 16'($urandom % 8);
                1: p = 16'hFFF8 + 16'($urandom % 8);
                default: p = 16'($urandom);
            endcase
            sel = $urandom % 16;
            l = (sel == 0) ? 3'($urandom) : ((sel < 6) ? 3'd1 : ((sel < 11) ? 3'd2 : 3'd4));
            mem_mode = $urandom % 4;
            if (k % 50 == 0) begin
                bm0_base_i = $urandom;
                bm1_base_i = $urandom;
            end
            run(p, l, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 5) != 0, 1'($urandom), (k % 37) == 0, "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule